// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block is a bus-slave register port that reaches a configuration register space through a pair of registers rather than through a flat map. Software first loads a 32-bit selector word into the pointer register at byte offset 0x28. It then reads or writes the data window at offset 0x2C to reach the configuration dword that the selector names. A small internal file of configuration dwords stands in for the device side.

The data window accepts byte, halfword and word accesses. The low two address bits of a sub-word access pick the starting byte lane. Write data arrives lane-aligned, and only the lanes that are covered by both the access size and the byte enables are changed. A read always returns the whole 32-bit dword, so software extracts a sub-word by shifting right by eight times the lane offset and masking. Any access whose shape is illegal is refused and reported as an error.

Every request is accepted in the cycle it is presented. Its response (valid, data and error) appears one cycle later.

Top module: `cfg_port`

## Requirements
- R1: After reset no response is valid, the pointer register reads 0 and every configuration dword reads 0.
- R2: A word access at offset 0x28 writes all 32 bits of the pointer register, whatever the byte enables, and reads it back unchanged. The value holds until the next such write. A byte or halfword access at 0x28 is an error and leaves the pointer unchanged.
- R3: While the pointer selects a present target, a word access at 0x2C reads or writes the dword whose index is pointer bits 7:2. Each dword is stored separately.
- R4: A write at 0x2C+k is a byte when size=0, a halfword when size=1 and a word when size=2. It changes only the byte lanes that lie inside the access (from lane k upward) and whose byte enable is set. Every other lane keeps its value, so a byte enable of 0000 changes nothing.
- R5: A read through the data window returns the full 32-bit dword whatever the size and lane offset of the read.
- R6: The target is present only when pointer bit 31 (enable) is 1 and bits 23:16 (bus), 15:11 (device) and 10:8 (function) are all 0. Otherwise data reads return FFFFFFFF and data writes leave every dword unchanged.
- R7: Size code 3 at the data window is an error. No dword changes, and the response data is 0.
- R8: At the data window, a halfword at lane offset 3 or a word at a nonzero lane offset is an error, and no dword changes.
- R9: On a present target, a dword index of NUM_REGS or more reads 0 and ignores writes. Index NUM_REGS-1 is stored.
- R10: Any other offset reads 0, ignores writes and is not an error.
- R11: Requests may come every cycle. Each response appears in the cycle after its request and reflects the pointer and dwords as they stood before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address within the control space |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| be | input | 4 | Byte enables for writes |
| wdata | input | 32 | Lane-aligned write data |
| rsp_valid | output | 1 | Response strobe, one cycle after req |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Access refused |

## Verification
Two things can fall in the same cycle: the pointer register being rewritten, and the response to a data-window read issued on the cycle before. The bench provokes this by issuing a pointer write, a window read, a second pointer write and a window read on four back-to-back cycles. Each read is judged against the dword chosen by the pointer that stood when that read was accepted. A late or early update of the pointer would return the neighbouring dword.

// File: rtl/cfg_port.sv
module cfg_port #(
  parameter int ADDR_W = 8,
  parameter int NUM_REGS = 16,
  parameter logic [ADDR_W-1:0] PTR_OFS = 8'h28,
  parameter logic [ADDR_W-1:0] WIN_OFS = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [6:0] NREG = NUM_REGS[6:0];

  logic [31:0] cfg_addr;
  logic [31:0] regs [NUM_REGS];
  logic [3:0]  span;
  logic [31:0] rd_val;

  wire [1:0] ofs     = addr[1:0];
  wire hit_ptr       = addr[ADDR_W-1:2] == PTR_OFS[ADDR_W-1:2];
  wire hit_win       = addr[ADDR_W-1:2] == WIN_OFS[ADDR_W-1:2];
  wire [5:0] idx     = cfg_addr[7:2];
  wire [IW-1:0] slot = idx[IW-1:0];
  wire present       = cfg_addr[31] && (cfg_addr[23:8] == 16'h0);
  wire in_range      = {1'b0, idx} < NREG;

  wire win_bad = (size == 2'd3) || (size == 2'd1 && ofs == 2'd3) || (size == 2'd2 && ofs != 2'd0);
  wire ptr_bad = (size != 2'd2) || (ofs != 2'd0);
  wire err     = (hit_win && win_bad) || (hit_ptr && ptr_bad);

  always_comb begin
    case (size)
      2'd0:    span = 4'b0001 << ofs;
      2'd1:    span = 4'b0011 << ofs;
      2'd2:    span = 4'b1111;
      default: span = 4'b0000;
    endcase
  end

  wire [3:0] lanes = span & be;
  wire wr_ptr = req && we && hit_ptr && !ptr_bad;
  wire wr_win = req && we && hit_win && !win_bad && present && in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_addr <= '0;
    else if (wr_ptr) cfg_addr <= wdata;
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NUM_REGS; g++) begin
      if (!rst_n) regs[g] <= '0;
      else if (wr_win && slot == IW'(g)) begin
        for (int b = 0; b < 4; b++)
          if (lanes[b]) regs[g][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_ptr) rd_val = cfg_addr;
    else if (hit_win) begin
      if (!present) rd_val = '1;
      else if (in_range) rd_val = regs[slot];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req;
      rsp_err   <= req && err;
      rsp_rdata <= (req && !we && !err) ? rd_val : 32'h0;
    end
  end
endmodule

module cfg_port_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PTR_OFS = 8'h28,
  parameter logic [ADDR_W-1:0] WIN_OFS = 8'h2C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic [31:0]       cfg_addr
);
  wire hw = addr[ADDR_W-1:2] == WIN_OFS[ADDR_W-1:2];
  wire hp = addr[ADDR_W-1:2] == PTR_OFS[ADDR_W-1:2];

  assert_rsp_next_R11: assert property (@(posedge clk) disable iff (!rst_n) req |=> rsp_valid);
  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n) !req |=> !rsp_valid);
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));
  assert_size3_err_R7: assert property (@(posedge clk) disable iff (!rst_n) (req && hw && size == 2'd3) |=> rsp_err);
  assert_misalign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hw && size == 2'd1 && addr[1:0] == 2'd3) |=> rsp_err);
  assert_absent_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && hw && size == 2'd2 && addr[1:0] == 2'd0 && !cfg_addr[31]) |=> rsp_rdata == 32'hFFFF_FFFF);
  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n) !(req && we && hp) |=> $stable(cfg_addr));
endmodule

bind cfg_port cfg_port_chk #(.ADDR_W(ADDR_W), .PTR_OFS(PTR_OFS), .WIN_OFS(WIN_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_addr(cfg_addr)
);

// File: tb/sim_cfg_port.sv
module sim_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [1:0] size = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_port u0 (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
               .be(be), .wdata(wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  // {req tag, we, addr, size, be, wdata, exp_err, exp_rdata}
  localparam int NV = 49;
  localparam logic [83:0] VEC [NV] = '{
    {4'd1,  1'b0, 8'h28, 2'd2, 4'hF, 32'h0,         1'b0, 32'h0},         // R1
    {4'd2,  1'b1, 8'h28, 2'd2, 4'h1, 32'h8000_0004, 1'b0, 32'h0},         // R2
    {4'd2,  1'b0, 8'h28, 2'd2, 4'hF, 32'h0,         1'b0, 32'h8000_0004}, // R2
    {4'd3,  1'b1, 8'h2C, 2'd2, 4'hF, 32'hDEAD_BEEF, 1'b0, 32'h0},         // R3
    {4'd3,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hDEAD_BEEF}, // R3
    {4'd4,  1'b1, 8'h2E, 2'd0, 4'h4, 32'h00AA_0000, 1'b0, 32'h0},         // R4
    {4'd5,  1'b0, 8'h2F, 2'd0, 4'h8, 32'h0,         1'b0, 32'hDEAA_BEEF}, // R5
    {4'd4,  1'b1, 8'h2D, 2'd1, 4'h6, 32'h0012_3400, 1'b0, 32'h0},         // R4
    {4'd4,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hDE12_34EF}, // R4
    {4'd8,  1'b1, 8'h2F, 2'd1, 4'hC, 32'hFFFF_FFFF, 1'b1, 32'h0},         // R8
    {4'd5,  1'b0, 8'h2E, 2'd1, 4'hC, 32'h0,         1'b0, 32'hDE12_34EF}, // R5
    {4'd7,  1'b1, 8'h2C, 2'd3, 4'hF, 32'h0,         1'b1, 32'h0},         // R7
    {4'd7,  1'b0, 8'h2C, 2'd3, 4'hF, 32'h0,         1'b1, 32'h0},         // R7
    {4'd8,  1'b1, 8'h2D, 2'd2, 4'hF, 32'h0,         1'b1, 32'h0},         // R8
    {4'd8,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hDE12_34EF}, // R8
    {4'd4,  1'b1, 8'h2C, 2'd0, 4'h0, 32'hFFFF_FFFF, 1'b0, 32'h0},         // R4
    {4'd4,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hDE12_34EF}, // R4
    {4'd4,  1'b1, 8'h2C, 2'd1, 4'h1, 32'h0000_5566, 1'b0, 32'h0},         // R4
    {4'd4,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hDE12_3466}, // R4
    {4'd3,  1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_0008, 1'b0, 32'h0},         // R3
    {4'd3,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'h0},         // R3
    {4'd3,  1'b1, 8'h2C, 2'd2, 4'hF, 32'h1122_3344, 1'b0, 32'h0},         // R3
    {4'd3,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'h1122_3344}, // R3
    {4'd6,  1'b1, 8'h28, 2'd2, 4'hF, 32'h0000_0004, 1'b0, 32'h0},         // R6
    {4'd6,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R6
    {4'd6,  1'b1, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'h0},         // R6
    {4'd6,  1'b1, 8'h28, 2'd2, 4'hF, 32'h8001_0004, 1'b0, 32'h0},         // R6
    {4'd6,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R6
    {4'd6,  1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_0804, 1'b0, 32'h0},         // R6
    {4'd6,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R6
    {4'd6,  1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_0104, 1'b0, 32'h0},         // R6
    {4'd6,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R6
    {4'd6,  1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_0004, 1'b0, 32'h0},         // R6
    {4'd6,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hDE12_3466}, // R6
    {4'd9,  1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_00FC, 1'b0, 32'h0},         // R9
    {4'd9,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'h0},         // R9
    {4'd9,  1'b1, 8'h2C, 2'd2, 4'hF, 32'h0000_0055, 1'b0, 32'h0},         // R9
    {4'd9,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'h0},         // R9
    {4'd10, 1'b1, 8'h20, 2'd2, 4'hF, 32'h1234_5678, 1'b0, 32'h0},         // R10
    {4'd10, 1'b0, 8'h20, 2'd2, 4'hF, 32'h0,         1'b0, 32'h0},         // R10
    {4'd2,  1'b0, 8'h28, 2'd2, 4'hF, 32'h0,         1'b0, 32'h8000_00FC}, // R2
    {4'd2,  1'b0, 8'h28, 2'd0, 4'h1, 32'h0,         1'b1, 32'h0},         // R2
    {4'd2,  1'b1, 8'h28, 2'd1, 4'h3, 32'h8000_0000, 1'b1, 32'h0},         // R2
    {4'd2,  1'b0, 8'h28, 2'd2, 4'hF, 32'h0,         1'b0, 32'h8000_00FC}, // R2
    {4'd9,  1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_0040, 1'b0, 32'h0},         // R9
    {4'd9,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'h0},         // R9
    {4'd9,  1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_003C, 1'b0, 32'h0},         // R9
    {4'd9,  1'b1, 8'h2C, 2'd2, 4'hF, 32'hA5A5_A5A5, 1'b0, 32'h0},         // R9
    {4'd9,  1'b0, 8'h2C, 2'd2, 4'hF, 32'h0,         1'b0, 32'hA5A5_A5A5}  // R9
  };

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,err,rdata} actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [7:0] a, input logic [1:0] s,
                       input logic [3:0] b, input logic [31:0] d);
    req = 1'b1; we = w; addr = a; size = s; be = b; wdata = d;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset response", {rsp_valid, rsp_err, rsp_rdata}, {1'b0, 1'b0, 32'h0});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][79], VEC[i][78:71], VEC[i][70:69], VEC[i][68:65], VEC[i][64:33]);
      @(negedge clk);
      req = 1'b0;
      check($sformatf("R%0d vector %0d", VEC[i][83:80], i), {rsp_valid, rsp_err, rsp_rdata},
            {1'b1, VEC[i][32], VEC[i][31:0]});
    end

    // R11: pointer rewrite lands in the same cycle as a window read response
    @(negedge clk);
    drive(1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_0008);
    @(negedge clk);
    check("R11 pointer write rsp", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 32'h0});
    drive(1'b0, 8'h2C, 2'd2, 4'hF, 32'h0);
    @(negedge clk);
    check("R11 read idx2", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 32'h1122_3344});
    drive(1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_0004);
    @(negedge clk);
    check("R11 second pointer write rsp", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 32'h0});
    drive(1'b0, 8'h2C, 2'd2, 4'hF, 32'h0);
    @(negedge clk);
    check("R11 read idx1", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 32'hDE12_3466});
    req = 1'b0;
    @(negedge clk);
    check("R11 idle after burst", {rsp_valid, rsp_err, rsp_rdata}, {1'b0, 1'b0, 32'h0});

    // R1: a second reset clears the pointer and the stored dwords
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 8'h28, 2'd2, 4'hF, 32'h0);
    @(negedge clk);
    check("R1 pointer after reset", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 32'h0});
    drive(1'b1, 8'h28, 2'd2, 4'hF, 32'h8000_0004);
    @(negedge clk);
    drive(1'b0, 8'h2C, 2'd2, 4'hF, 32'h0);
    @(negedge clk);
    req = 1'b0;
    check("R1 dword after reset", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 32'h0});

    done = 1;
    summary();
  end
endmodule